// File: doc/BRIEF.md
# Block Move and Compare Sequencer

This block carries out the repeating and single-step block move and block compare operations of an 8-bit accumulator machine. It works through a byte-wide memory port. A decoded command selects three things: move or compare, the direction in which the pointers step, and single or repeating operation. The caller supplies the starting source pointer, destination pointer, 16-bit count, accumulator and flag byte, then pulses `start`. The sequencer reads each source byte and, for a move, writes it to the destination. It then updates the pointers, the count and the flags once per iteration. When it finishes, it presents the final register values with a one-cycle `done` pulse.

Every iteration has a fixed nominal length in clock states. An iteration that is followed by another takes the long length. A single step, or the last iteration of a repeat, takes the short length. Memory accesses use a request/acknowledge handshake. Any cycle in which a request waits for its acknowledge is added on top of the nominal length.

Top module: `blk_xfer_seq`

## Requirements
- R1: A move (`op_move`=1) copies the byte at address `hl_in` to address `de_in` and decrements the count by one. Both pointers then step by +1 when `op_dec`=0, or by -1 when `op_dec`=1. Exactly one memory write is made per iteration.
- R2: A repeating move (`op_rep`=1) iterates until the count reaches zero. It always finishes with P/V cleared and the count equal to zero.
- R3: A compare (`op_move`=0) reads the byte at the source pointer and forms accumulator minus byte without storing it. It decrements the count and steps the source pointer in the selected direction. The destination pointer is left unchanged and nothing is written. A repeating compare stops after the first iteration in which the byte equals the accumulator, or in which the count reaches zero.
- R4: With memory that acknowledges in the same cycle, `done` rises exactly N clock edges after the edge that samples `start`. N is 12 for a single step. For a repeat, N is 14 per continuing iteration plus 12 for the final one. `done` is high for one cycle only.
- R5: Flag byte layout is S=bit 7, Z=bit 6, H=bit 4, P/V=bit 2, N=bit 1 and C=bit 0; bits 5 and 3 pass through. For a compare, the flags are set as follows:
  - S is bit 7 of the 8-bit difference.
  - Z is set when the byte equals the accumulator.
  - H is the borrow out of bit 3.
  - N is set.
  - P/V is set when the decremented count is nonzero.
  - C is unchanged.
- R6: For a move, H and N are cleared, and S, Z and C are unchanged. P/V is set when the decremented count is nonzero.
- R7: Pointer and count arithmetic wraps modulo 2^16. A count of zero at start decrements to 0xFFFF and the operation continues.
- R8: A memory request keeps its address and direction stable until it is acknowledged. Wait cycles lengthen the operation but do not change its results.
- R9: `start` is ignored while the sequencer is busy.
- R10: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| op_move | input | 1 | 1 = move, 0 = compare |
| op_dec | input | 1 | 1 = pointers step down, 0 = step up |
| op_rep | input | 1 | 1 = repeat until a stop condition |
| hl_in | input | 16 | Starting source pointer |
| de_in | input | 16 | Starting destination pointer |
| bc_in | input | 16 | Starting byte count |
| a_in | input | 8 | Accumulator for compare |
| f_in | input | 8 | Incoming flag byte |
| hl_out | output | 16 | Current/final source pointer |
| de_out | output | 16 | Current/final destination pointer |
| bc_out | output | 16 | Current/final count |
| f_out | output | 8 | Current/final flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The assertions assume that `mem_rdata` is valid in the cycle that `mem_ack` is high during a read. They also assume that `mem_ack` is only meaningful while `mem_req` is high. The bench's memory model drives both combinationally from its own array, and it only ever acknowledges a pending request. Command and register inputs are assumed stable only at the sampling edge. The bench changes them only when the block is idle, apart from one deliberate mid-run poke that tests R9.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_PAD
  } seq_st_e;

  typedef struct packed {
    logic move;
    logic dec;
    logic rep;
  } blk_cmd_t;

  // flag byte bit positions
  localparam int FL_S  = 7;
  localparam int FL_Z  = 6;
  localparam int FL_H  = 4;
  localparam int FL_PV = 2;
  localparam int FL_N  = 1;
  localparam int FL_C  = 0;

endpackage

// File: rtl/blkseq_step.sv
module blkseq_step
  import blkseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  blk_cmd_t        cmd,
  input  logic [AW-1:0]   hl,
  input  logic [AW-1:0]   de,
  input  logic [CW-1:0]   bc,
  input  logic [DW-1:0]   acc,
  input  logic [DW-1:0]   rd,
  input  logic [7:0]      flags,
  output logic [AW-1:0]   hl_n,
  output logic [AW-1:0]   de_n,
  output logic [CW-1:0]   bc_n,
  output logic [7:0]      flags_n,
  output logic            cont
);

  logic [DW-1:0] diff;
  logic [4:0]    low_diff;
  logic          eq;
  logic          bc_live;

  assign diff     = acc - rd;
  assign low_diff = {1'b0, acc[3:0]} - {1'b0, rd[3:0]};
  assign eq       = (diff == '0);
  assign bc_n     = bc - CW'(1);
  assign bc_live  = |bc_n;
  assign hl_n     = cmd.dec ? hl - AW'(1) : hl + AW'(1);

  always_comb begin
    flags_n        = flags;
    flags_n[FL_PV] = bc_live;
    if (cmd.move) begin
      de_n          = cmd.dec ? de - AW'(1) : de + AW'(1);
      flags_n[FL_H] = 1'b0;
      flags_n[FL_N] = 1'b0;
      cont          = cmd.rep & bc_live;
    end else begin
      de_n          = de;
      flags_n[FL_S] = diff[DW-1];
      flags_n[FL_Z] = eq;
      flags_n[FL_H] = low_diff[4];
      flags_n[FL_N] = 1'b1;
      cont          = cmd.rep & bc_live & ~eq;
    end
  end

endmodule

// File: rtl/blkseq_timer.sv
module blkseq_timer #(
  parameter int SHORT_ST = 12,
  parameter int LONG_ST  = 14,
  localparam int CNT_W   = $clog2(LONG_ST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             long_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(SHORT_ST - 1);
  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(LONG_ST - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == (long_sel ? LONG_END : SHORT_END));
  assign last   = adv & at_end;
  assign cnt    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)           cnt_d = '0;
    else if (adv)      cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: state count never runs past the long iteration length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LONG_END);

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blkseq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int COUNT_W  = 16,
  parameter int DATA_W   = 8,
  parameter int SHORT_ST = 12,
  parameter int LONG_ST  = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op_move,
  input  logic               op_dec,
  input  logic               op_rep,
  input  logic [ADDR_W-1:0]  hl_in,
  input  logic [ADDR_W-1:0]  de_in,
  input  logic [COUNT_W-1:0] bc_in,
  input  logic [DATA_W-1:0]  a_in,
  input  logic [7:0]         f_in,
  output logic [ADDR_W-1:0]  hl_out,
  output logic [ADDR_W-1:0]  de_out,
  output logic [COUNT_W-1:0] bc_out,
  output logic [7:0]         f_out,
  output logic               busy,
  output logic               done,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_ack
);

  localparam int TCNT_W = $clog2(LONG_ST);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  seq_st_e            state_q, state_d;
  blk_cmd_t           cmd_q;
  logic [ADDR_W-1:0]  hl_q, de_q;
  logic [COUNT_W-1:0] bc_q;
  logic [DATA_W-1:0]  a_q, rd_q;
  logic [7:0]         f_q;
  logic               done_q, done_d;

  logic               load, commit, rd_en, adv, clr;
  logic [ADDR_W-1:0]  hl_n, de_n;
  logic [COUNT_W-1:0] bc_n;
  logic [7:0]         f_n;
  logic               cont;
  logic [TCNT_W-1:0]  tcnt;
  logic               last;

  blkseq_step #(.AW(ADDR_W), .CW(COUNT_W), .DW(DATA_W)) u_step (
    .cmd     (cmd_q),
    .hl      (hl_q),
    .de      (de_q),
    .bc      (bc_q),
    .acc     (a_q),
    .rd      (rd_q),
    .flags   (f_q),
    .hl_n    (hl_n),
    .de_n    (de_n),
    .bc_n    (bc_n),
    .flags_n (f_n),
    .cont    (cont)
  );

  blkseq_timer #(.SHORT_ST(SHORT_ST), .LONG_ST(LONG_ST)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sn),
    .clr      (clr),
    .adv      (adv),
    .long_sel (cont),
    .cnt      (tcnt),
    .last     (last)
  );

  // next-state and memory port decode
  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    commit   = 1'b0;
    rd_en    = 1'b0;
    adv      = 1'b0;
    clr      = 1'b0;
    done_d   = 1'b0;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = hl_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          clr     = 1'b1;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          rd_en   = 1'b1;
          adv     = 1'b1;
          state_d = cmd_q.move ? ST_WRITE : ST_PAD;
        end
      end
      ST_WRITE: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = de_q;
        if (mem_ack) begin
          adv     = 1'b1;
          state_d = ST_PAD;
        end
      end
      ST_PAD: begin
        adv = 1'b1;
        if (last) begin
          commit  = 1'b1;
          state_d = cont ? ST_READ : ST_IDLE;
          done_d  = ~cont;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      cmd_q   <= '0;
      hl_q    <= '0;
      de_q    <= '0;
      bc_q    <= '0;
      a_q     <= '0;
      f_q     <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (load) begin
        cmd_q <= '{move: op_move, dec: op_dec, rep: op_rep};
        hl_q  <= hl_in;
        de_q  <= de_in;
        bc_q  <= bc_in;
        a_q   <= a_in;
        f_q   <= f_in;
      end else if (commit) begin
        hl_q <= hl_n;
        de_q <= de_n;
        bc_q <= bc_n;
        f_q  <= f_n;
      end
      if (rd_en) rd_q <= mem_rdata;
    end
  end

  assign hl_out    = hl_q;
  assign de_out    = de_q;
  assign bc_out    = bc_q;
  assign f_out     = f_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign mem_wdata = rd_q;

  // R8: a pending request holds address and direction
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4: completion is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  // R5: carry untouched while an operation runs
  a_r5_carry_kept: assert property (@(posedge clk) disable iff (!rst_sn)
    busy |=> $stable(f_out[FL_C]));

  // R2: repeating move ends with zero count and P/V clear
  a_r2_move_end: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && cmd_q.rep && cmd_q.move) |-> (bc_out == '0 && !f_out[FL_PV]));

  // R3: repeating compare ends on a match or an exhausted count
  a_r3_cmp_end: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && cmd_q.rep && !cmd_q.move) |-> (bc_out == '0 || f_out[FL_Z]));

endmodule

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;

  typedef struct packed {
    logic        mv, dec, rep;
    logic [15:0] hl, de, bc;
    logic [7:0]  a, f;
    logic [15:0] ehl, ede, ebc;
    logic [7:0]  ef;
    logic [15:0] est, ewr, caddr;
    logic [7:0]  cval;
  } vec_t;

  localparam int NV = 10;
  // memory is preset to mem[addr] = addr[7:0] before each run
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0, 16'h1010,16'h2000,16'h0003, 8'h00,8'hD3, 16'h1011,16'h2001,16'h0002, 8'hC5, 16'd12,16'd1,16'h2000,8'h10},
    '{1'b1,1'b0,1'b1, 16'h1000,16'h3000,16'h0004, 8'h00,8'h00, 16'h1004,16'h3004,16'h0000, 8'h00, 16'd54,16'd4,16'h3003,8'h03},
    '{1'b1,1'b1,1'b1, 16'h1105,16'h4105,16'h0003, 8'h00,8'h01, 16'h1102,16'h4102,16'h0000, 8'h01, 16'd40,16'd3,16'h4103,8'h03},
    '{1'b1,1'b1,1'b0, 16'h0003,16'h0000,16'h0001, 8'h00,8'h04, 16'h0002,16'hFFFF,16'h0000, 8'h00, 16'd12,16'd1,16'h0000,8'h03},
    '{1'b0,1'b0,1'b0, 16'h2030,16'h1234,16'h0005, 8'h30,8'h01, 16'h2031,16'h1234,16'h0004, 8'h47, 16'd12,16'd0,16'h2030,8'h30},
    '{1'b0,1'b0,1'b0, 16'h2001,16'h1234,16'h0001, 8'h00,8'h00, 16'h2002,16'h1234,16'h0000, 8'h92, 16'd12,16'd0,16'h2001,8'h01},
    '{1'b0,1'b0,1'b1, 16'h5010,16'h1234,16'h000A, 8'h13,8'h00, 16'h5014,16'h1234,16'h0006, 8'h46, 16'd54,16'd0,16'h5010,8'h10},
    '{1'b0,1'b0,1'b1, 16'h6020,16'h1234,16'h0003, 8'h05,8'h01, 16'h6023,16'h1234,16'h0000, 8'h83, 16'd40,16'd0,16'h6020,8'h20},
    '{1'b0,1'b0,1'b1, 16'h7040,16'h1234,16'h0002, 8'h41,8'h00, 16'h7042,16'h1234,16'h0000, 8'h42, 16'd26,16'd0,16'h7040,8'h40},
    '{1'b0,1'b0,1'b1, 16'h8000,16'h1234,16'h0000, 8'h01,8'h28, 16'h8002,16'h1234,16'hFFFE, 8'h6E, 16'd26,16'd0,16'h8000,8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_move = 1'b0, op_dec = 1'b0, op_rep = 1'b0;
  logic [15:0] hl_in = '0, de_in = '0, bc_in = '0;
  logic [7:0]  a_in = '0, f_in = '0;
  logic [15:0] hl_out, de_out, bc_out, mem_addr;
  logic [7:0]  f_out, mem_wdata, mem_rdata;
  logic        busy, done, mem_req, mem_we, mem_ack;

  logic [7:0]  mem [0:65535];
  logic        mem_init = 1'b0;
  logic        slow = 1'b0;
  logic        slow_ok = 1'b0;
  int          wr_cnt = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz

  blk_xfer_seq i_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_move(op_move), .op_dec(op_dec), .op_rep(op_rep),
    .hl_in(hl_in), .de_in(de_in), .bc_in(bc_in), .a_in(a_in), .f_in(f_in),
    .hl_out(hl_out), .de_out(de_out), .bc_out(bc_out), .f_out(f_out),
    .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // memory model
  assign mem_rdata = mem[mem_addr];
  assign mem_ack   = mem_req && (!slow || slow_ok);

  always @(negedge clk) slow_ok <= ~slow_ok;

  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < 65536; i++) mem[i] <= 8'(i);
      wr_cnt <= 0;
    end else if (mem_req && mem_we && mem_ack) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // runs one operation; returns states from the sampling edge to done
  task automatic run(input vec_t v, input bit slow_m, input int poke,
                     output int states);
    int cyc;
    @(negedge clk) mem_init = 1'b1;
    @(negedge clk) mem_init = 1'b0;
    slow    = slow_m;
    op_move = v.mv; op_dec = v.dec; op_rep = v.rep;
    hl_in = v.hl; de_in = v.de; bc_in = v.bc; a_in = v.a; f_in = v.f;
    start = 1'b1;
    cyc = 0;
    while (1) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      start = (cyc == poke);
      if (cyc == poke) begin
        hl_in = 16'hDEAD; de_in = 16'hBEEF; bc_in = 16'h0001; op_move = 1'b0;
      end
      if (done || cyc > 5000) break;
    end
    start  = 1'b0;
    slow   = 1'b0;
    states = cyc - 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int st;
    vec_t d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    chk("R10", "busy", busy, 0);
    chk("R10", "done", done, 0);
    chk("R10", "mem_req", mem_req, 0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i], 1'b0, -1, st);
      chk(VEC[i].mv ? "R1" : "R3", "hl", hl_out, VEC[i].ehl);
      chk(VEC[i].mv ? "R1" : "R3", "de", de_out, VEC[i].ede);
      chk(VEC[i].mv ? "R1" : "R3", "bc", bc_out, VEC[i].ebc);
      chk(VEC[i].mv ? "R6" : "R5", "flags", f_out, VEC[i].ef);
      chk("R4", "states", st, VEC[i].est);
      chk(VEC[i].mv ? "R1" : "R3", "writes", wr_cnt, VEC[i].ewr);
      chk(VEC[i].mv ? "R1" : "R3", "mem", mem[VEC[i].caddr], VEC[i].cval);
      @(negedge clk);
      chk("R4", "done width", done, 0);
    end

    // R2: repeating move with count 1 takes one short iteration
    d = VEC[1];
    d.bc = 16'h0001;
    run(d, 1'b0, -1, st);
    chk("R2", "states", st, 12);
    chk("R2", "bc", bc_out, 0);
    chk("R2", "flags", f_out, 8'h00);

    // R7: count 0 wraps to FFFF, pointer FFFF wraps to 0000
    d = '{1'b1,1'b0,1'b0, 16'hFFFF,16'h0100,16'h0000, 8'h00,8'h00,
          16'h0000,16'h0101,16'hFFFF, 8'h04, 16'd12,16'd1,16'h0100,8'hFF};
    run(d, 1'b0, -1, st);
    chk("R7", "hl", hl_out, 16'h0000);
    chk("R7", "de", de_out, 16'h0101);
    chk("R7", "bc", bc_out, 16'hFFFF);
    chk("R7", "flags", f_out, 8'h04);
    chk("R7", "mem", mem[16'h0100], 8'hFF);

    // R8: wait states lengthen but do not alter results
    run(VEC[2], 1'b1, -1, st);
    chk("R8", "hl", hl_out, VEC[2].ehl);
    chk("R8", "de", de_out, VEC[2].ede);
    chk("R8", "bc", bc_out, VEC[2].ebc);
    chk("R8", "mem", mem[VEC[2].caddr], VEC[2].cval);
    chk("R8", "slower", (st > 40) ? 1 : 0, 1);

    // R9: start while busy is ignored
    run(VEC[1], 1'b0, 7, st);
    chk("R9", "hl", hl_out, VEC[1].ehl);
    chk("R9", "de", de_out, VEC[1].ede);
    chk("R9", "bc", bc_out, VEC[1].ebc);
    chk("R9", "states", st, VEC[1].est);
    chk("R9", "writes", wr_cnt, VEC[1].ewr);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule